// File: doc/BRIEF.md
# Dual-Rail Delay-Insensitive Link

This block is a clocked model of a self-timed link with no request wire. On the send side, a word taken from a valid/ready port is turned into rail codes and driven onto the wires. Between two words the wires return to an all-zero spacer. The receive side decides from the wires alone when a word has fully arrived. It recovers the word, raises an acknowledge that runs back to the sender, and drops that acknowledge once every wire has returned to zero.

The parameter `ONE_OF_FOUR` picks the code. With 0 (dual-rail), each data bit has two wires. With 1 (1-of-4), each two-bit digit has four wires and exactly one of them is high. Both codes use `2*W` wires, so the link width does not depend on the mode. `W` must be even when `ONE_OF_FOUR` is 1. Codes that no legal sender can produce set a sticky error flag. Normally the user connects `rail_out` to `rail_in` across the link and `ack_out` to `ack_in`.

Top module: `rail_link`

## Requirements
- R1: Dual-rail code (`ONE_OF_FOUR`=0): data bit i owns wires 2i and 2i+1. A 0 is sent as wire 2i high (pair value 2'b01), a 1 as wire 2i+1 high (pair value 2'b10). 2'b00 is the spacer.
- R2: 1-of-4 code (`ONE_OF_FOUR`=1): digit d is data bits [2d+1:2d] and owns wires 4d to 4d+3. A digit of value v is sent as wire 4d+v alone high. 4'b0000 is the spacer.
- R3: `in_ready` is high only while the sender drives the spacer and `ack_in` is low. An accepted word appears on `rail_out` one cycle after acceptance. It is held until `ack_in` is seen high, and the next cycle `rail_out` is all zero.
- R4: `ack_out` rises only when every digit on `rail_in` holds a valid code. In that same cycle `out_valid` is high for exactly one cycle and `out_data` carries the decoded word. A partly arrived word raises neither.
- R5: Once high, `ack_out` stays high until every wire of `rail_in` is zero, including while only some digits have returned to the spacer.
- R6: A dual-rail pair reading 2'b11, or a 1-of-4 digit with more than one high wire, sets `err` on the next clock. `err` stays set until reset and does not itself raise `ack_out`.
- R7: While and after reset, `rail_out` is zero, `ack_out`, `out_valid` and `err` are low, and `in_ready` is high once `ack_in` is low.
- R8: When the two sides are connected back to back, every word sent is delivered unchanged and in order, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word offered to the sender |
| in_ready | output | 1 | Sender takes the word this cycle |
| in_data | input | W | Word to send |
| rail_out | output | 2*W | Rail wires driven by the sender |
| ack_in | input | 1 | Acknowledge returning to the sender |
| rail_in | input | 2*W | Rail wires seen by the receiver |
| ack_out | output | 1 | Acknowledge driven by the receiver |
| out_valid | output | 1 | One-cycle pulse when a word is recovered |
| out_data | output | W | Recovered word |
| err | output | 1 | Sticky flag for an illegal rail code |

## Verification
The bench injects words that have only partly arrived; a receiver that tested any digit rather than every digit would acknowledge them early. It holds the acknowledge while some digits have already returned to zero, which catches a receiver that lowers on the first spacer digit. It also forces 2'b11 pairs and two-hot 1-of-4 digits and then releases them, which exposes a missing or non-sticky error flag. A design that swapped the wire order within a pair or within a digit is caught by comparing the sent rails against codes the bench builds itself from R1 and R2.

// File: rtl/rail_link.sv
module rail_link #(
  parameter int W = 8,
  parameter bit ONE_OF_FOUR = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  output logic [2*W-1:0] rail_out,
  input  logic           ack_in,
  input  logic [2*W-1:0] rail_in,
  output logic           ack_out,
  output logic           out_valid,
  output logic [W-1:0]   out_data,
  output logic           err
);
  localparam int NR = 2 * W;
  localparam int ND = ONE_OF_FOUR ? W / 2 : W;

  logic [NR-1:0] code;
  logic [W-1:0]  dec;
  logic [ND-1:0] dig_ok;
  logic [ND-1:0] dig_bad;

  genvar g;
  generate
    for (g = 0; g < ND; g++) begin : g_dig
      if (ONE_OF_FOUR) begin : g_q
        logic [3:0] c;
        assign c = rail_in[4*g +: 4];
        assign dig_ok[g]  = (c == 4'b0001) || (c == 4'b0010) ||
                            (c == 4'b0100) || (c == 4'b1000);
        assign dig_bad[g] = (c & (c - 4'd1)) != 4'd0;
        assign dec[2*g +: 2] = {c[3] | c[2], c[3] | c[1]};
        assign code[4*g +: 4] = 4'b0001 << in_data[2*g +: 2];
      end else begin : g_d
        logic [1:0] c;
        assign c = rail_in[2*g +: 2];
        assign dig_ok[g]  = c[0] ^ c[1];
        assign dig_bad[g] = c[0] & c[1];
        assign dec[g] = c[1];
        assign code[2*g +: 2] = in_data[g] ? 2'b10 : 2'b01;
      end
    end
  endgenerate

  logic          busy;
  logic [NR-1:0] rail_q;

  assign in_ready = !busy && !ack_in;
  assign rail_out = rail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      rail_q <= '0;
    end else if (in_ready && in_valid) begin
      busy   <= 1'b1;
      rail_q <= code;
    end else if (busy && ack_in) begin
      busy   <= 1'b0;
      rail_q <= '0;
    end
  end

  logic         ack_q, vld_q, err_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= 1'b0;
      err_q <= err_q | (|dig_bad);
      if (!ack_q && (&dig_ok)) begin
        ack_q  <= 1'b1;
        vld_q  <= 1'b1;
        data_q <= dec;
      end else if (ack_q && (rail_in == '0)) begin
        ack_q <= 1'b0;
      end
    end
  end

  assign ack_out   = ack_q;
  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign err       = err_q;
endmodule

// File: rtl/rail_link_chk.sv
module rail_link_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [2*W-1:0] rail_out,
  input logic           ack_in,
  input logic [2*W-1:0] rail_in,
  input logic           ack_out,
  input logic           out_valid,
  input logic           err
);
  p_ready_spacer_r3: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!ack_in && rail_out == '0));

  p_hold_code_r3: assert property (@(posedge clk) disable iff (rst)
    (rail_out != '0 && !ack_in) |=> $stable(rail_out));

  p_spacer_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (rail_out != '0 && ack_in) |=> rail_out == '0);

  p_ack_with_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_out) |-> out_valid);

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_ack_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_out && rail_in != '0) |=> ack_out);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_reset_quiet_r7: assert property (@(posedge clk)
    rst |=> (!err && !ack_out && !out_valid && rail_out == '0));
endmodule

bind rail_link rail_link_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .rail_out(rail_out), .ack_in(ack_in), .rail_in(rail_in),
  .ack_out(ack_out), .out_valid(out_valid), .err(err)
);

// File: tb/rail_link_tb.sv
module rail_link_tb_top;
  localparam int W = 8;
  localparam int NR = 2 * W;
  localparam int NV = 8;
  localparam logic [W-1:0] VEC [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h5A,
                                        8'h01, 8'h80, 8'h3C, 8'hE4};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic inj_d = 1'b0, inj_q = 1'b0;
  logic [NR-1:0] inj_vd = '0, inj_vq = '0;

  logic rdy_d, ack_d, vld_d, err_d, rdy_q, ack_q, vld_q, err_q;
  logic [NR-1:0] ro_d, ro_q, ri_d, ri_q;
  logic [W-1:0] od_d, od_q;

  assign ri_d = inj_d ? inj_vd : ro_d;
  assign ri_q = inj_q ? inj_vq : ro_q;

  rail_link #(.W(W), .ONE_OF_FOUR(1'b0)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_d),
    .in_data(in_data), .rail_out(ro_d), .ack_in(ack_d), .rail_in(ri_d),
    .ack_out(ack_d), .out_valid(vld_d), .out_data(od_d), .err(err_d));

  rail_link #(.W(W), .ONE_OF_FOUR(1'b1)) dut_q (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_q),
    .in_data(in_data), .rail_out(ro_q), .ack_in(ack_q), .rail_in(ri_q),
    .ack_out(ack_q), .out_valid(vld_q), .out_data(od_q), .err(err_q));

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] dcode(input logic [W-1:0] w);
    logic [NR-1:0] r = '0;
    for (int i = 0; i < W; i++) r[2*i + (w[i] ? 1 : 0)] = 1'b1;
    return r;
  endfunction

  function automatic logic [NR-1:0] qcode(input logic [W-1:0] w);
    logic [NR-1:0] r = '0;
    for (int d = 0; d < W / 2; d++) r[4*d + int'(w[2*d +: 2])] = 1'b1;
    return r;
  endfunction

  task automatic send(input logic [W-1:0] w);
    int n;
    @(negedge clk);
    in_data = w; in_valid = 1'b1;
    n = 0;
    while (!(rdy_d && rdy_q) && n < 50) begin @(negedge clk); n++; end
    chk("R3 ready before send", {rdy_d, rdy_q}, 2'b11);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 rails held before ack", {ack_d, ack_q}, 2'b00);
    n = 0;
    while (!vld_d && n < 20) begin @(negedge clk); n++; end
    chk("R4 valid pulse both modes", {vld_d, vld_q, ack_d, ack_q}, 4'hF);
    chk("R1 dual-rail wires", ro_d, dcode(w));
    chk("R2 one-of-four wires", ro_q, qcode(w));
    chk("R8 dual word", od_d, w);
    chk("R8 quad word", od_q, w);
    @(negedge clk);
    chk("R4 pulse one cycle", {vld_d, vld_q}, 2'b00);
    chk("R3 spacer after ack", {ro_d, ro_q}, '0);
    n = 0;
    while ((ack_d || ack_q) && n < 20) begin @(negedge clk); n++; end
    chk("R5 ack low after spacer", {ack_d, ack_q}, 2'b00);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset outputs", {ro_d, ro_q, ack_d, ack_q, vld_d, vld_q, err_d, err_q}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 ready after reset", {rdy_d, rdy_q}, 2'b11);

    for (int i = 0; i < NV; i++) send(VEC[i]);
    for (int i = 0; i < 20; i++) send(W'($urandom));
    chk("R6 no error on legal traffic", {err_d, err_q}, 2'b00);

    // partial word in dual-rail: only bit0 carries a code
    @(negedge clk);
    inj_d = 1'b1; inj_vd = 16'h0001;
    repeat (2) @(negedge clk);
    chk("R4 partial word no ack", {ack_d, vld_d, err_d}, 3'b000);
    inj_vd = dcode(8'hC3);
    @(negedge clk);
    chk("R4 completed word acked", {ack_d, vld_d}, 2'b11);
    chk("R4 completed word data", od_d, 8'hC3);
    chk("R3 ready low while ack high", rdy_d, 1'b0);
    inj_vd = 16'h0002;
    repeat (2) @(negedge clk);
    chk("R5 ack held on partial spacer", ack_d, 1'b1);
    inj_vd = '0;
    @(negedge clk);
    chk("R5 ack low on full spacer", ack_d, 1'b0);
    inj_vd = 16'h0003;
    @(negedge clk);
    chk("R6 dual 11 sets err", {err_d, ack_d}, 2'b10);
    inj_vd = '0;
    repeat (2) @(negedge clk);
    chk("R6 dual err sticky", err_d, 1'b1);
    inj_d = 1'b0;

    // one-of-four: partial digit then two-hot digit
    inj_q = 1'b1; inj_vq = 16'h0004;
    repeat (2) @(negedge clk);
    chk("R4 quad partial no ack", {ack_q, vld_q, err_q}, 3'b000);
    inj_vq = 16'h0003;
    @(negedge clk);
    chk("R6 quad two-hot sets err", {err_q, ack_q}, 2'b10);
    inj_vq = '0;
    repeat (2) @(negedge clk);
    chk("R6 quad err sticky", err_q, 1'b1);
    inj_q = 1'b0;

    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 reset clears err", {err_d, err_q}, 2'b00);
    rst = 1'b0;
    send(8'h96);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule